// File: doc/BRIEF.md
# FIFO-fill VCO rate controller

This block sits on the receive side of a bit-stream demapper. Extracted bytes are written into a 32-entry byte FIFO. A downstream serial clock enable drains the FIFO one bit per cycle, most significant bit first. The FIFO occupancy acts as the phase detector of an external rate-adaptation loop.

The block compares the occupancy with two 5-bit thresholds set by software. It asks an external filter and oscillator to speed up when the FIFO is filling, or to slow down when it is draining. A one-cycle strobe marks every change of that request pair. Writes into a full FIFO and reads from an empty one are reported as a corruption pulse.

While disabled, the block is flushed and silent. After enable, reading starts only once the FIFO has filled to a synchronization level. This places the loop near mid-fill before the output clock runs. The whole block runs on one clock, with separate write and read enables.

Top module: `fill_rate_ctrl`

## Requirements
- R1: Each accepted byte leaves on `ser_bit` MSB first, one bit per cycle in which `rd_en` is high. A bit is valid in the cycle after its `rd_en` cycle, marked by `ser_valid`. Bytes leave in write order.
- R2: After enable rises, `rd_en` is ignored until the fill level has reached `SYNC_LEVEL` bytes. `ser_bit` is 0 whenever `ser_valid` is 0.
- R3: While `enable` is low, the following hold:
    - the FIFO is emptied;
    - `wr_en` and `rd_en` are ignored;
    - `ser_valid`, `ser_bit`, `vco_up`, `vco_down` and `corrupt` are 0 from the next cycle on.
- R4: `vco_up` is 1 in the cycle after one in which the fill level is greater than `hi_mark`, and 0 otherwise (with enable high).
- R5: `vco_down` is 1 in the cycle after one in which the fill level is less than `lo_mark`, and 0 otherwise. A `lo_mark` of 0 never requests a decrease.
- R6: `vco_update` is a one-cycle pulse in exactly those cycles in which `vco_up` or `vco_down` takes a new value.
- R7: A write while the FIFO holds 32 bytes and no byte is read out that cycle is dropped. `corrupt` is 1 for one cycle, in the cycle after the dropped write.
- R8: Starting a byte while the FIFO is empty sends the byte 0x00 and raises `corrupt` for one cycle, in the cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low flushes the FIFO and silences the outputs |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Extracted byte to buffer |
| rd_en | input | 1 | Serial bit clock enable |
| hi_mark | input | 5 | Fill level above which a faster clock is requested |
| lo_mark | input | 5 | Fill level below which a slower clock is requested |
| ser_bit | output | 1 | Serial data bit |
| ser_valid | output | 1 | `ser_bit` carries a bit this cycle |
| vco_up | output | 1 | Request to raise the output clock rate |
| vco_down | output | 1 | Request to lower the output clock rate |
| vco_update | output | 1 | One-cycle strobe on any change of the request pair |
| corrupt | output | 1 | One-cycle overflow or underflow event |

## Verification
The bench builds the block with the default 32-byte depth and with `SYNC_LEVEL` lowered to 4. The low sync level lets the bench exercise the pre-synchronization hold, then the read path, within a few writes. The full-depth FIFO lets a 32-byte fill reach the full boundary, where a dropped write can be shown missing from the drained stream. Thresholds of 3 and 10 place both request edges and their update strobes within a short fill. An underflow after a full drain shows the 0x00 byte. A final `lo_mark` of 0 shows that the decrease request stays silent.

// File: rtl/rfc_pkg.sv
// Shared types for the FIFO-fill rate controller.
package rfc_pkg;
    // Registered pair of rate requests driven to the external filter.
    typedef struct packed {
        logic up;
        logic down;
    } rate_req_t;
endpackage

// File: rtl/rfc_byte_fifo.sv
// Byte FIFO with occupancy output.
// Assumes a single clock. A flush empties it in one cycle.
// A push into a full FIFO is dropped unless a pop happens the same cycle.
// A pop from an empty FIFO returns zero and leaves the pointers alone.
module rfc_byte_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    fill,
    output logic             overflow,
    output logic             underflow
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             full, empty, do_push, do_pop;

    // Derive the accepted operations and the error events for this cycle.
    always_comb begin
        full      = (fill == CW'(DEPTH));
        empty     = (fill == '0);
        do_pop    = pop && !empty;
        do_push   = push && (!full || do_pop);
        overflow  = push && full && !do_pop;
        underflow = pop && empty;
        dout      = empty ? '0 : mem[rd_ptr];
    end

    // Store accepted bytes.
    always_ff @(posedge clk) begin
        if (do_push && !flush)
            mem[wr_ptr] <= din;
    end

    // Advance the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            fill <= fill + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/rfc_bit_serializer.sv
// Turns bytes into a serial stream, MSB first, one bit per go cycle.
// It asks for a new byte (pop) on the first go cycle of each byte.
// The output is registered, so a bit is valid the cycle after its go.
module rfc_bit_serializer #(
    parameter int WIDTH = 8,
    localparam int BW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             go,
    input  logic [WIDTH-1:0] byte_in,
    output logic             pop,
    output logic             ser_bit,
    output logic             ser_valid
);
    logic [WIDTH-1:0] shreg;
    logic [BW-1:0]    bits_left;

    // A new byte is taken when the previous one is fully sent.
    always_comb pop = go && (bits_left == '0);

    // Shift out one bit per go cycle; hold the line low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            shreg     <= '0;
            bits_left <= '0;
            ser_bit   <= 1'b0;
            ser_valid <= 1'b0;
        end else begin
            ser_valid <= go;
            if (pop) begin
                ser_bit   <= byte_in[WIDTH-1];
                shreg     <= {byte_in[WIDTH-2:0], 1'b0};
                bits_left <= BW'(WIDTH - 1);
            end else if (go) begin
                ser_bit   <= shreg[WIDTH-1];
                shreg     <= {shreg[WIDTH-2:0], 1'b0};
                bits_left <= bits_left - 1'b1;
            end else begin
                ser_bit   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rfc_rate_cmp.sv
// Compares the FIFO fill level with the two thresholds.
// Registers the increase/decrease request pair.
// Pulses an update strobe in the cycle the pair changes.
// Assumes the marks are stable software values.
module rfc_rate_cmp #(
    parameter int CW = 6,
    parameter int MARK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CW-1:0]     fill,
    input  logic [MARK_W-1:0] hi_mark,
    input  logic [MARK_W-1:0] lo_mark,
    output rfc_pkg::rate_req_t req,
    output logic              update
);
    rfc_pkg::rate_req_t req_n;

    // Threshold decisions for the next cycle.
    always_comb begin
        req_n.up   = enable && (fill > CW'(hi_mark));
        req_n.down = enable && (fill < CW'(lo_mark));
    end

    // Register the requests and flag any change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req    <= '0;
            update <= 1'b0;
        end else begin
            req    <= req_n;
            update <= (req_n != req);
        end
    end
endmodule

// File: rtl/fill_rate_ctrl.sv
// FIFO-fill VCO rate controller.
// Buffers extracted bytes and serializes them under rd_en.
// Uses the fill level to drive rate requests to an external loop.
// One clock; enable low flushes everything.
// Reads start after the fill reaches SYNC_LEVEL following enable.
module fill_rate_ctrl #(
    parameter int DEPTH      = 32,
    parameter int WIDTH      = 8,
    parameter int MARK_W     = 5,
    parameter int SYNC_LEVEL = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [MARK_W-1:0] hi_mark,
    input  logic [MARK_W-1:0] lo_mark,
    output logic              ser_bit,
    output logic              ser_valid,
    output logic              vco_up,
    output logic              vco_down,
    output logic              vco_update,
    output logic              corrupt
);
    logic [CW-1:0]      fill;
    logic [WIDTH-1:0]   head;
    logic               pop, go, synced, ovf, unf;
    rfc_pkg::rate_req_t req;

    rfc_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(!enable),
        .push(wr_en && enable), .din(wr_data), .pop(pop), .dout(head),
        .fill(fill), .overflow(ovf), .underflow(unf)
    );

    // Reading is allowed only once synchronized.
    always_comb go = rd_en && synced && enable;

    rfc_bit_serializer #(.WIDTH(WIDTH)) u_ser (
        .clk(clk), .rst_n(rst_n), .enable(enable), .go(go),
        .byte_in(head), .pop(pop), .ser_bit(ser_bit), .ser_valid(ser_valid)
    );

    rfc_rate_cmp #(.CW(CW), .MARK_W(MARK_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fill(fill),
        .hi_mark(hi_mark), .lo_mark(lo_mark), .req(req), .update(vco_update)
    );

    always_comb begin
        vco_up   = req.up;
        vco_down = req.down;
    end

    // Synchronization: set once the fill reaches the sync level; cleared by disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            synced <= 1'b0;
        else if (fill >= CW'(SYNC_LEVEL))
            synced <= 1'b1;
    end

    // Corruption event: one-cycle pulse per overflow or underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)
            corrupt <= 1'b0;
        else
            corrupt <= ovf || unf;
    end
endmodule

// File: rtl/rfc_checker.sv
// Property checker for fill_rate_ctrl, attached with bind.
module rfc_checker #(
    parameter int DEPTH  = 32,
    parameter int MARK_W = 5,
    parameter int CW     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              rd_en,
    input logic [MARK_W-1:0] hi_mark,
    input logic [CW-1:0]     fill,
    input logic              ser_bit,
    input logic              ser_valid,
    input logic              vco_up,
    input logic              vco_down,
    input logic              vco_update
);
    // R1: a valid bit always follows a read-enable cycle.
    a_r1_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> $past(rd_en));

    // R2: the line is low whenever no bit is valid.
    a_r2_idle_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |-> !ser_bit);

    // R3: disabling silences the data and request outputs.
    a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ser_valid && !vco_up && !vco_down));

    // R4: an increase request needs a fill above the high mark one cycle earlier.
    a_r4_up_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
        vco_up |-> ($past(fill) > CW'($past(hi_mark))));

    // R6: the strobe marks exactly the changes of the request pair.
    a_r6_update_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        vco_update == ((vco_up != $past(vco_up)) || (vco_down != $past(vco_down))));

    // R7: the occupancy never exceeds the depth.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));
endmodule

bind fill_rate_ctrl rfc_checker #(.DEPTH(DEPTH), .MARK_W(MARK_W), .CW(CW)) u_rfc_checker (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rd_en(rd_en),
    .hi_mark(hi_mark), .fill(fill), .ser_bit(ser_bit), .ser_valid(ser_valid),
    .vco_up(vco_up), .vco_down(vco_down), .vco_update(vco_update)
);

// File: tb/test_fill_rate_ctrl.sv
`timescale 1ns/1ps
module test_fill_rate_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [4:0] hi_mark = 5'd10, lo_mark = 5'd3;
    logic ser_bit, ser_valid, vco_up, vco_down, vco_update, corrupt;

    int checks = 0, errors = 0, model_cnt = 0, n_corrupt = 0;
    logic [7:0] exp_q [$];
    logic [7:0] acc;
    int nbits = 0;

    always #2 clk = ~clk;

    fill_rate_ctrl #(.SYNC_LEVEL(4)) i_fill_rate_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .hi_mark(hi_mark), .lo_mark(lo_mark),
        .ser_bit(ser_bit), .ser_valid(ser_valid), .vco_up(vco_up),
        .vco_down(vco_down), .vco_update(vco_update), .corrupt(corrupt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one byte write; expected bytes go to the scoreboard queue.
    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        if (model_cnt < 32) begin
            exp_q.push_back(b);
            model_cnt++;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: read n whole bytes; an empty model read expects 0x00 (R8).
    task automatic rd_bytes(input int n);
        for (int i = 0; i < n * 8; i++) begin
            @(negedge clk);
            rd_en = 1'b1;
            if (i % 8 == 0) begin
                if (model_cnt == 0) exp_q.push_back(8'h00);
                else model_cnt--;
            end
        end
        @(negedge clk);
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: rebuild bytes MSB first and compare with the queue (R1).
    always @(negedge clk) begin
        if (rst_n && corrupt) n_corrupt++;
        if (rst_n && ser_valid) begin
            acc = {acc[6:0], ser_bit};
            nbits++;
            if (nbits == 8) begin
                nbits = 0;
                if (exp_q.size() == 0) chk(1'b0, "R1 unexpected byte", acc, -1);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(acc == e, "R1 serial byte", acc, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        chk(!ser_valid && !ser_bit && !vco_up && !vco_down && !vco_update && !corrupt,
            "R3 reset state", {ser_valid, vco_up, vco_down, corrupt}, 0);
        rst_n = 1'b1;

        // R3: while disabled, writes and reads are ignored.
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'h77;
        repeat (4) @(negedge clk);
        chk(!ser_valid && !corrupt && !vco_down, "R3 disabled ignores inputs",
            {ser_valid, corrupt, vco_down}, 0);
        rd_en = 1'b0; wr_en = 1'b0;

        // R5/R6: enabled with an empty FIFO requests a decrease.
        enable = 1'b1;
        @(negedge clk);
        chk(vco_down == 1'b1, "R5 down when fill below low mark", vco_down, 1);
        chk(vco_update == 1'b1, "R6 update on down rise", vco_update, 1);
        @(negedge clk);
        chk(vco_update == 1'b0, "R6 update is one cycle", vco_update, 0);

        // R2: below the sync level, reads are ignored.
        wr(8'hA1); wr(8'h5C); wr(8'h80);
        @(negedge clk);
        chk(vco_down == 1'b0, "R5 down drops at low mark", vco_down, 1'b0);
        rd_en = 1'b1;
        repeat (5) @(negedge clk);
        chk(!ser_valid && !ser_bit && !corrupt, "R2 no output before sync",
            {ser_valid, ser_bit, corrupt}, 0);
        rd_en = 1'b0;
        wr(8'h01);
        @(negedge clk);
        rd_bytes(4);
        chk(exp_q.size() == 0, "R1 first bytes drained", exp_q.size(), 0);

        // R4/R6: fill above the high mark.
        for (int i = 0; i < 11; i++) wr(8'(i * 17 + 3));
        @(negedge clk);
        chk(vco_up == 1'b1, "R4 up when fill above high mark", vco_up, 1);
        chk(vco_update == 1'b1, "R6 update on up rise", vco_update, 1);
        chk(vco_down == 1'b0, "R5 no down when filled", vco_down, 0);
        rd_bytes(1);
        chk(vco_up == 1'b0, "R4 up drops at high mark", vco_up, 0);

        // R7: write to a full FIFO is dropped and flagged.
        for (int i = 0; i < 22; i++) wr(8'(8'hC0 ^ i));
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hEE;
        @(negedge clk);
        wr_en = 1'b0;
        chk(corrupt == 1'b1, "R7 overflow raises corrupt", corrupt, 1);
        @(negedge clk);
        chk(corrupt == 1'b0, "R7 corrupt is one cycle", corrupt, 0);
        rd_bytes(32);
        chk(exp_q.size() == 0, "R7 dropped byte absent from stream", exp_q.size(), 0);

        // R8: read from empty gives 0x00 and one corrupt pulse.
        c0 = n_corrupt;
        rd_bytes(1);
        chk(n_corrupt - c0 == 1, "R8 underflow raises corrupt once", n_corrupt - c0, 1);
        chk(exp_q.size() == 0, "R8 zero byte delivered", exp_q.size(), 0);

        // R3: disable silences requests; R5: low mark 0 never requests decrease.
        enable = 1'b0;
        @(negedge clk);
        chk(!vco_up && !vco_down, "R3 disable clears requests", {vco_up, vco_down}, 0);
        model_cnt = 0;
        lo_mark = 5'd0; hi_mark = 5'd31;
        enable = 1'b1;
        repeat (3) @(negedge clk);
        chk(vco_down == 1'b0, "R5 low mark zero never decreases", vco_down, 0);

        // R2: re-enable needs fresh synchronization.
        wr(8'h11); wr(8'h22); wr(8'h33);
        rd_en = 1'b1;
        repeat (4) @(negedge clk);
        chk(!ser_valid, "R2 resync required after enable", ser_valid, 0);
        rd_en = 1'b0;
        wr(8'h44);
        @(negedge clk);
        rd_bytes(4);
        chk(exp_q.size() == 0, "R1 bytes after resync", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule